// File: doc/BRIEF.md
# Immediate Control Block Command Decoder

This block accepts the two-word immediate control block that accompanies an operate-I/O instruction. The first word carries an 8-bit opcode in its upper byte and an 8-bit device address in its lower byte. When that address equals the strapped address of this attachment, the block latches the first word into its command register. It then decodes the opcode. Direct programmed commands treat the second word as immediate data. The cycle-steal Start command treats the second word as the storage address of the first control block to fetch.

Every accepted or refused command returns a condition code one cycle after the strobe. A Prepare command sets the interrupt level and arms one disk unit's request trigger. Start hands a block address and a one-cycle start pulse to the transfer engine, and the attachment stays busy until that engine reports completion. While units are armed, their interrupt requests are collected in a per-unit pending register, including while a transfer is running.

Top module: `idcb_decoder`

## Requirements
- R1: After reset, every output register is zero, `busy`, `start_pulse` and `cc_valid` are low, and `cc` is 0.
- R2: A strobe whose word-0 low byte equals `strap_addr` loads all of word 0 into `cmd_reg` at the next clock edge. In that same edge it raises `cc_valid` for one cycle. `cc` takes one of three codes: 1 for accepted, 2 for busy, 3 for reject.
- R3: A strobe whose address byte differs from `strap_addr` produces no `cc_valid` and changes no output register.
- R4: Prepare (opcode 0x01) loads `level_reg` from bits 11 to 14 of word 1 in most-significant-first numbering, which is `word1[4:1]`. It returns code 1.
- R5: Prepare sets the `unit_req` bit selected by `word1[15:14]` and leaves the other bits unchanged.
- R6: Start (opcode 0x02) issued while idle loads `dcb_addr` with word 1, pulses `start_pulse` for exactly one cycle, sets `busy` and returns code 1.
- R7: Start issued while `busy` is high returns code 2, leaves `dcb_addr` unchanged and gives no `start_pulse`.
- R8: `xfer_done` clears `busy` at the next clock edge. A Start that arrives on the same edge still sees the attachment busy.
- R9: Write-data (opcode 0x04) loads `dpc_data` with word 1 and returns code 1.
- R10: Any other opcode returns code 3. `level_reg`, `unit_req`, `dcb_addr`, `dpc_data` and `busy` stay unchanged.
- R11: A high `unit_intr[i]` sets `intr_pend[i]` at the next edge only if `unit_req[i]` is set, and this works whether or not `busy` is high. The pending bit holds until cleared.
- R12: Clear (opcode 0x03) zeroes `unit_req` and `intr_pend` and returns code 1. An interrupt from a unit that was armed before the Clear, arriving on the same edge, still sets its pending bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| idcb_valid | input | 1 | One-cycle strobe for the two words |
| idcb_word0 | input | 16 | Opcode (bits 15:8) and device address (bits 7:0) |
| idcb_word1 | input | 16 | Immediate data or control block address |
| strap_addr | input | 8 | Strapped attachment address |
| xfer_done | input | 1 | Transfer engine has left auto mode |
| unit_intr | input | 4 | Per-unit interrupt requests |
| cmd_reg | output | 16 | Last accepted word 0 |
| level_reg | output | 4 | Prepared interrupt level |
| unit_req | output | 4 | Per-unit request triggers |
| intr_pend | output | 4 | Per-unit pending interrupts |
| dcb_addr | output | 16 | Address of the first control block word |
| dpc_data | output | 16 | Last immediate data word |
| start_pulse | output | 1 | One-cycle start to the transfer engine |
| busy | output | 1 | Auto transfer in progress |
| cc_valid | output | 1 | Condition code valid |
| cc | output | 2 | Condition code |

## Verification
The bench builds the block with its default parameters: 16-bit words, an 8-bit address and four units. With those values, every unit trigger and both extremes of the two-bit unit field can be reached with a handful of Prepare commands. The level field sits at a fixed offset, so patterns that set only its edge bits can expose a shifted slice. The 8-bit address space makes near-miss addresses that differ by one bit cheap to try. Busy overlap cases are covered as well: a Start while busy, and a Start on the same edge as completion.

// File: rtl/idcb_pkg.sv
package idcb_pkg;
  localparam logic [7:0] OP_PREPARE = 8'h01;
  localparam logic [7:0] OP_START   = 8'h02;
  localparam logic [7:0] OP_CLEAR   = 8'h03;
  localparam logic [7:0] OP_WDATA   = 8'h04;

  typedef enum logic [1:0] {
    CC_NONE   = 2'd0,
    CC_ACCEPT = 2'd1,
    CC_BUSY   = 2'd2,
    CC_REJECT = 2'd3
  } cc_e;

  typedef struct packed {
    logic prep;
    logic start;
    logic clear;
    logic wdata;
    logic bad;
  } op_t;
endpackage

// File: rtl/idcb_match.sv
module idcb_match #(
  parameter int ADDR_W = 8
) (
  input  logic              valid,
  input  logic [ADDR_W-1:0] dev_field,
  input  logic [ADDR_W-1:0] strap,
  output logic              hit
);
  always_comb begin
    hit = valid && (dev_field == strap);
  end
endmodule

// File: rtl/idcb_op_decode.sv
module idcb_op_decode
  import idcb_pkg::*;
#(
  parameter int OP_W = 8
) (
  input  logic [OP_W-1:0] opcode,
  output op_t             op
);
  always_comb begin
    op = '0;
    unique case (opcode)
      OP_PREPARE: op.prep  = 1'b1;
      OP_START:   op.start = 1'b1;
      OP_CLEAR:   op.clear = 1'b1;
      OP_WDATA:   op.wdata = 1'b1;
      default:    op.bad   = 1'b1;
    endcase
  end
endmodule

// File: rtl/idcb_decoder.sv
module idcb_decoder
  import idcb_pkg::*;
#(
  parameter int WORD_W    = 16,
  parameter int ADDR_W    = 8,
  parameter int NUM_UNITS = 4,
  parameter int LVL_W     = 4,
  parameter int LVL_FIRST = 11
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 idcb_valid,
  input  logic [WORD_W-1:0]    idcb_word0,
  input  logic [WORD_W-1:0]    idcb_word1,
  input  logic [ADDR_W-1:0]    strap_addr,
  input  logic                 xfer_done,
  input  logic [NUM_UNITS-1:0] unit_intr,
  output logic [WORD_W-1:0]    cmd_reg,
  output logic [LVL_W-1:0]     level_reg,
  output logic [NUM_UNITS-1:0] unit_req,
  output logic [NUM_UNITS-1:0] intr_pend,
  output logic [WORD_W-1:0]    dcb_addr,
  output logic [WORD_W-1:0]    dpc_data,
  output logic                 start_pulse,
  output logic                 busy,
  output logic                 cc_valid,
  output logic [1:0]           cc
);
  localparam int OP_W    = WORD_W - ADDR_W;
  localparam int UNIT_W  = (NUM_UNITS > 1) ? $clog2(NUM_UNITS) : 1;
  localparam int LVL_LSB = WORD_W - LVL_FIRST - LVL_W;

  logic hit;
  op_t  op;

  idcb_match #(.ADDR_W(ADDR_W)) u_match (
    .valid     (idcb_valid),
    .dev_field (idcb_word0[ADDR_W-1:0]),
    .strap     (strap_addr),
    .hit       (hit)
  );

  idcb_op_decode #(.OP_W(OP_W)) u_dec (
    .opcode (idcb_word0[WORD_W-1 -: OP_W]),
    .op     (op)
  );

  logic [UNIT_W-1:0]    unit_sel;
  logic [NUM_UNITS-1:0] unit_hot;
  assign unit_sel = idcb_word1[WORD_W-1 -: UNIT_W];

  for (genvar gi = 0; gi < NUM_UNITS; gi++) begin : g_unit
    assign unit_hot[gi] = (unit_sel == UNIT_W'(gi));
  end

  // next-state
  logic                 do_prep, do_start, do_clear, do_wdata, do_busy;
  logic                 busy_d;
  logic [NUM_UNITS-1:0] req_d, pend_d;
  cc_e                  cc_d;

  always_comb begin
    do_prep  = hit && op.prep;
    do_clear = hit && op.clear;
    do_wdata = hit && op.wdata;
    do_start = hit && op.start && !busy;
    do_busy  = hit && op.start && busy;

    busy_d = busy;
    if (xfer_done) busy_d = 1'b0;
    if (do_start)  busy_d = 1'b1;

    req_d = unit_req;
    if (do_clear) req_d = '0;
    if (do_prep)  req_d = unit_req | unit_hot;

    pend_d = (do_clear ? '0 : intr_pend) | (unit_intr & unit_req);

    if (op.bad)      cc_d = CC_REJECT;
    else if (do_busy) cc_d = CC_BUSY;
    else             cc_d = CC_ACCEPT;
  end

  // registers
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cmd_reg     <= '0;
      level_reg   <= '0;
      unit_req    <= '0;
      intr_pend   <= '0;
      dcb_addr    <= '0;
      dpc_data    <= '0;
      start_pulse <= 1'b0;
      busy        <= 1'b0;
      cc_valid    <= 1'b0;
      cc          <= 2'd0;
    end else begin
      start_pulse <= do_start;
      cc_valid    <= hit;
      busy        <= busy_d;
      unit_req    <= req_d;
      intr_pend   <= pend_d;
      if (hit)      cmd_reg   <= idcb_word0;
      if (hit)      cc        <= cc_d;
      if (do_prep)  level_reg <= idcb_word1[LVL_LSB +: LVL_W];
      if (do_start) dcb_addr  <= idcb_word1;
      if (do_wdata) dpc_data  <= idcb_word1;
    end
  end

  // assertions
  a_r3_no_code_on_mismatch: assert property (@(posedge clk) disable iff (!rst_n)
    (idcb_valid && idcb_word0[ADDR_W-1:0] != strap_addr) |=> !cc_valid);
  a_r6_pulse_with_busy: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |-> busy);
  a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    start_pulse |=> !start_pulse);
  a_r7_busy_code_only_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (cc_valid && cc == CC_BUSY) |-> $past(busy));
  a_r7_addr_held_while_busy: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !xfer_done) |=> $stable(dcb_addr));
  a_r5_one_trigger_per_cmd: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(unit_req & ~$past(unit_req)));
  a_r11_pend_needs_arm: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(intr_pend[0]) |-> $past(unit_req[0]));
endmodule

// File: tb/tb_idcb_decoder.sv
module tb_idcb_decoder;
  localparam int CLK_PERIOD = 10;

  logic        clk = 0;
  logic        rst_n;
  logic        idcb_valid;
  logic [15:0] idcb_word0, idcb_word1;
  logic [7:0]  strap_addr;
  logic        xfer_done;
  logic [3:0]  unit_intr;
  logic [15:0] cmd_reg, dcb_addr, dpc_data;
  logic [3:0]  level_reg, unit_req, intr_pend;
  logic        start_pulse, busy, cc_valid;
  logic [1:0]  cc;

  int checks = 0, fails = 0;
  logic [1:0] exp_q[$];

  idcb_decoder dut (
    .clk(clk), .rst_n(rst_n), .idcb_valid(idcb_valid), .idcb_word0(idcb_word0),
    .idcb_word1(idcb_word1), .strap_addr(strap_addr), .xfer_done(xfer_done),
    .unit_intr(unit_intr), .cmd_reg(cmd_reg), .level_reg(level_reg),
    .unit_req(unit_req), .intr_pend(intr_pend), .dcb_addr(dcb_addr),
    .dpc_data(dpc_data), .start_pulse(start_pulse), .busy(busy),
    .cc_valid(cc_valid), .cc(cc)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // monitor: compares condition codes against the scoreboard queue
  always @(negedge clk) begin
    if (rst_n && cc_valid) begin
      if (exp_q.size() == 0) check("R3 unexpected code", {30'd0, cc}, 32'hFFFF);
      else check("R2 condition code", {30'd0, cc}, {30'd0, exp_q.pop_front()});
    end
  end

  // driver: one strobe, pushes the expected code when addressed here
  task automatic issue(input logic [7:0] opc, input logic [7:0] adr,
                       input logic [15:0] w1, input logic [1:0] exp_cc);
    @(negedge clk);
    idcb_valid = 1; idcb_word0 = {opc, adr}; idcb_word1 = w1;
    if (adr == strap_addr) exp_q.push_back(exp_cc);
    @(negedge clk);
    idcb_valid = 0;
  endtask

  initial begin
    #(CLK_PERIOD*2000);
    check("watchdog", 0, 1);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    rst_n = 0; idcb_valid = 0; idcb_word0 = 0; idcb_word1 = 0;
    strap_addr = 8'h5A; xfer_done = 0; unit_intr = 0;
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1
    check("R1 cmd_reg", cmd_reg, 0);
    check("R1 level/req/pend", {level_reg, unit_req, intr_pend}, 0);
    check("R1 dcb/data", {dcb_addr, dpc_data}, 0);
    check("R1 flags", {start_pulse, busy, cc_valid, cc}, 0);

    // R4 R5 R2: prepare unit 3, level bits 11..14 = word1[4:1] = 4'b1001
    issue(8'h01, 8'h5A, 16'hC012, 2'd1);
    check("R2 cmd_reg", cmd_reg, 16'h015A);
    check("R4 level", level_reg, 4'h9);
    check("R5 unit 3", unit_req, 4'b1000);
    // R5 unit 0, level 4'b0110
    issue(8'h01, 8'h5A, 16'h000C, 2'd1);
    check("R5 unit 0 added", unit_req, 4'b1001);
    check("R4 level 2", level_reg, 4'h6);

    // R3 mismatch: near-miss address
    issue(8'h01, 8'h5B, 16'h4000, 2'd0);
    check("R3 regs unchanged", {cmd_reg, unit_req, level_reg}, {16'h015A, 4'b1001, 4'h6});
    issue(8'h02, 8'hDA, 16'h1234, 2'd0);
    check("R3 no start", {start_pulse, busy, dcb_addr}, 0);

    // R9
    issue(8'h04, 8'h5A, 16'hBEEF, 2'd1);
    check("R9 dpc_data", dpc_data, 16'hBEEF);

    // R10
    issue(8'h7F, 8'h5A, 16'hFFFF, 2'd3);
    check("R10 no change", {level_reg, unit_req, dcb_addr, dpc_data, busy},
          {4'h6, 4'b1001, 16'h0, 16'hBEEF, 1'b0});

    // R6: start pulse visible one cycle after strobe
    @(negedge clk);
    idcb_valid = 1; idcb_word0 = 16'h025A; idcb_word1 = 16'h8642;
    exp_q.push_back(2'd1);
    @(negedge clk);
    idcb_valid = 0;
    check("R6 pulse", start_pulse, 1);
    check("R6 dcb_addr", dcb_addr, 16'h8642);
    check("R6 busy", busy, 1);
    @(negedge clk);
    check("R6 pulse one cycle", start_pulse, 0);

    // R11 posting during busy, masked unit ignored
    unit_intr = 4'b0011;
    @(negedge clk);
    unit_intr = 0;
    check("R11 armed only", intr_pend, 4'b0001);
    @(negedge clk);
    check("R11 held", intr_pend, 4'b0001);

    // R7
    issue(8'h02, 8'h5A, 16'h1111, 2'd2);
    check("R7 addr held", dcb_addr, 16'h8642);
    check("R7 no pulse", {start_pulse, busy}, 2'b01);

    // R8 start on the same edge as completion sees busy
    @(negedge clk);
    idcb_valid = 1; idcb_word0 = 16'h025A; idcb_word1 = 16'h2222; xfer_done = 1;
    exp_q.push_back(2'd2);
    @(negedge clk);
    idcb_valid = 0; xfer_done = 0;
    check("R8 busy cleared", busy, 0);
    check("R8 same-edge start refused", {start_pulse, dcb_addr}, {1'b0, 16'h8642});

    // R12 clear with simultaneous armed interrupt on unit 3
    @(negedge clk);
    idcb_valid = 1; idcb_word0 = 16'h035A; idcb_word1 = 0; unit_intr = 4'b1000;
    exp_q.push_back(2'd1);
    @(negedge clk);
    idcb_valid = 0; unit_intr = 0;
    check("R12 req cleared", unit_req, 0);
    check("R12 same-edge post kept", intr_pend, 4'b1000);
    unit_intr = 4'b1111;
    @(negedge clk);
    unit_intr = 0;
    check("R11 disarmed ignored", intr_pend, 4'b1000);

    repeat (2) @(negedge clk);
    check("R2 scoreboard drained", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule